// File: doc/BRIEF.md
# Serial EEPROM Sequential Word Reader

This block fetches a run of consecutive 16-bit words from a three-wire-plus-select serial EEPROM. It drives the chip select, the serial clock and the data line into the memory, and it samples the data line coming back. A single-cycle start pulse loads a start address and a word count. The block then issues one complete read command frame for every word in the run. Each captured word is presented for one system clock, together with the address it came from. A done pulse closes the run.

The serial clock is derived from the system clock. Its high time and low time are each a parameterised number of system cycles, so the timing limits of the memory can be met at any system frequency. Each frame has four parts: an opening clock cycle with select high, the three command bits, the word address, and seventeen reply cycles. Select then drops for one clock cycle before the next frame. The address width is a parameter and is either 6 or 8 bits. Only reads are generated.

Top module: `mw_seq_reader`

## Requirements
- R1: Each frame begins with chip select rising while the serial clock is low. One full serial clock cycle follows with the data line at 0, before any command bit is sent.
- R2: The next three bits sent on the serial data line, one per rising edge, are 1, 1, 0. The first 1 is the start bit and 10 is the read opcode.
- R3: The word address follows the command bits, one bit per rising edge, most significant bit first. It is exactly ADDR_W bits long, and ADDR_W is 6 or 8.
- R4: The frame then runs 17 reply cycles, so one frame has 21+ADDR_W rising edges with select high. The first reply bit is a dummy zero and is discarded. The remaining 16 bits form the word, most significant bit first.
- R5: After each frame, chip select is low for exactly one serial clock cycle before the next frame starts or the run ends.
- R6: The words are read from start_addr_i up to start_addr_i+count_i-1, with addresses wrapping modulo 2^ADDR_W. Each word gives exactly one word_vld_o pulse of one cycle, carrying word_o and word_addr_o. The pulse comes after select has dropped.
- R7: The serial clock stays high for exactly HI_CYC system cycles and low for exactly LO_CYC system cycles within a run.
- R8: The data line into the memory changes only while the serial clock is low. Returned data is sampled in the last low cycle before a rising edge.
- R9: A start with count_i equal to 0 gives done_o in the next cycle. busy_o stays low, and select, clock and data do not toggle.
- R10: When start_i arrives while idle with a nonzero count, busy_o goes high in the next cycle and stays high until the done cycle. A start_i during a run is ignored.
- R11: done_o is a single-cycle pulse. It coincides with the first cycle in which busy_o is low again.
- R12: While idle, and after reset, select, clock and data are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Run start pulse |
| start_addr_i | input | ADDR_W | First word address |
| count_i | input | ADDR_W+1 | Number of words to read |
| cs_o | output | 1 | Memory chip select, active high |
| sck_o | output | 1 | Serial clock to memory |
| sdo_o | output | 1 | Serial data to memory |
| sdi_i | input | 1 | Serial data from memory |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished pulse |
| word_vld_o | output | 1 | Word valid pulse |
| word_o | output | 16 | Captured word |
| word_addr_o | output | ADDR_W | Address of captured word |

## Verification
The bound checker watches several rules on every cycle. It checks that the outgoing data line stays still across each high clock phase. It checks that the high phase lasts exactly the configured count and that select only rises with the clock low. It checks that the lines are quiet while idle, that busy only rises after a start, and that busy only falls together with done. Only the bench scenarios can show that the frame contents are right: the leading idle cycle, the 1-1-0 command, the address order, the 17-cycle reply with the dummy zero dropped, and the single select-low cycle between frames. The bench also covers address wrap, the zero-count shortcut and a start ignored mid-run, comparing each delivered word against a behavioural memory model.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int WORD_W    = 16;
  localparam int CMD_LEN   = 3;
  localparam logic [CMD_LEN-1:0] CMD_BITS = 3'b110;
  localparam int REPLY_LEN = WORD_W + 1;
  localparam int IDX_W     = $clog2(REPLY_LEN);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_CMD,
    ST_ADR,
    ST_DAT,
    ST_POST
  } mw_state_e;
endpackage

// File: rtl/mw_sck_gen.sv
module mw_sck_gen #(
  parameter int HI_CYC = 188,
  parameter int LO_CYC = 63
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sck_o,
  output logic rise_o,
  output logic slot_end_o
);
  localparam int MAXC  = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             hi_q;

  assign rise_o     = en_i && !hi_q && (cnt_q == CNT_W'(LO_CYC - 1));
  assign slot_end_o = en_i &&  hi_q && (cnt_q == CNT_W'(HI_CYC - 1));
  assign sck_o      = hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hi_q  <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      hi_q  <= 1'b0;
    end else if (rise_o) begin
      cnt_q <= '0;
      hi_q  <= 1'b1;
    end else if (slot_end_o) begin
      cnt_q <= '0;
      hi_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mw_tx_mux.sv
module mw_tx_mux
  import mw_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  mw_state_e         state_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              sdo_o
);
  localparam int AW_IDX = $clog2(ADDR_W);

  logic [1:0]        cmd_sel;
  logic [AW_IDX-1:0] adr_sel;

  assign cmd_sel = 2'(CMD_LEN - 1) - idx_i[1:0];
  assign adr_sel = AW_IDX'(ADDR_W - 1) - idx_i[AW_IDX-1:0];

  always_comb begin
    unique case (state_i)
      ST_CMD:  sdo_o = CMD_BITS[cmd_sel];
      ST_ADR:  sdo_o = addr_i[adr_sel];
      default: sdo_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/mw_rx_shift.sv
module mw_rx_shift
  import mw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  // 17 shifts into 16 bits: the dummy lead bit drops off the top
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_o <= '0;
    else if (shift_i) word_o <= {word_o[WORD_W-2:0], bit_i};
  end
endmodule

// File: rtl/mw_seq_reader.sv
module mw_seq_reader
  import mw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int HI_CYC = 188,
  parameter int LO_CYC = 63
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [ADDR_W:0]   count_i,
  output logic              cs_o,
  output logic              sck_o,
  output logic              sdo_o,
  input  logic              sdi_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o,
  output logic [ADDR_W-1:0] word_addr_o
);
  mw_state_e         state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W:0]   left_q;
  logic              rise, slot_end, run;
  logic [WORD_W-1:0] rx_word;

  assign run    = (state_q != ST_IDLE);
  assign busy_o = run;
  assign cs_o   = run && (state_q != ST_POST);

  mw_sck_gen #(.HI_CYC(HI_CYC), .LO_CYC(LO_CYC)) sck_gen_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (run),
    .sck_o      (sck_o),
    .rise_o     (rise),
    .slot_end_o (slot_end)
  );

  mw_tx_mux #(.ADDR_W(ADDR_W)) tx_i (
    .state_i (state_q),
    .idx_i   (idx_q),
    .addr_i  (addr_q),
    .sdo_o   (sdo_o)
  );

  mw_rx_shift rx_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (rise && (state_q == ST_DAT)),
    .bit_i   (sdi_i),
    .word_o  (rx_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      addr_q      <= '0;
      left_q      <= '0;
      done_o      <= 1'b0;
      word_vld_o  <= 1'b0;
      word_o      <= '0;
      word_addr_o <= '0;
    end else begin
      done_o     <= 1'b0;
      word_vld_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (count_i == '0) begin
              done_o <= 1'b1;
            end else begin
              state_q <= ST_PRE;
              addr_q  <= start_addr_i;
              left_q  <= count_i;
              idx_q   <= '0;
            end
          end
        end
        ST_PRE: if (slot_end) begin
          state_q <= ST_CMD;
          idx_q   <= '0;
        end
        ST_CMD: if (slot_end) begin
          if (idx_q == IDX_W'(CMD_LEN - 1)) begin
            state_q <= ST_ADR;
            idx_q   <= '0;
          end else idx_q <= idx_q + 1'b1;
        end
        ST_ADR: if (slot_end) begin
          if (idx_q == IDX_W'(ADDR_W - 1)) begin
            state_q <= ST_DAT;
            idx_q   <= '0;
          end else idx_q <= idx_q + 1'b1;
        end
        ST_DAT: if (slot_end) begin
          if (idx_q == IDX_W'(REPLY_LEN - 1)) begin
            state_q     <= ST_POST;
            idx_q       <= '0;
            word_vld_o  <= 1'b1;
            word_o      <= rx_word;
            word_addr_o <= addr_q;
            left_q      <= left_q - 1'b1;
          end else idx_q <= idx_q + 1'b1;
        end
        ST_POST: if (slot_end) begin
          if (left_q == '0) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
          end else begin
            state_q <= ST_PRE;
            addr_q  <= addr_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mw_seq_reader_chk.sv
module mw_seq_reader_chk #(
  parameter int HI_CYC = 188
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic cs_o,
  input logic sck_o,
  input logic sdo_o,
  input logic busy_o,
  input logic done_o,
  input logic word_vld_o
);
  logic [15:0] hi_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hi_len <= '0;
    else if (sck_o) hi_len <= hi_len + 1'b1;
    else            hi_len <= '0;
  end

  assert_sdo_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(sdo_o));

  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!cs_o && !sck_o && !sdo_o));

  assert_done_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_busy_fall_done_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  assert_busy_rise_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  assert_vld_after_frame_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> (busy_o && !cs_o));

  assert_high_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sck_o) |-> (hi_len == 16'(HI_CYC)));

  assert_cs_rise_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_o) |-> !sck_o);
endmodule

bind mw_seq_reader mw_seq_reader_chk #(.HI_CYC(HI_CYC)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .cs_o       (cs_o),
  .sck_o      (sck_o),
  .sdo_o      (sdo_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .word_vld_o (word_vld_o)
);

// File: tb/mw_seq_reader_tb.sv
`timescale 1ns/1ps
module mw_seq_reader_tb_top;
  localparam int AW = 8;
  localparam int HI = 3;
  localparam int LO = 2;
  localparam int FRAME_RISES = 21 + AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] saddr = '0;
  logic [AW:0]   cnt = '0;
  logic cs, sck, sdo, sdi, busy, done, vld;
  logic [15:0]   word;
  logic [AW-1:0] waddr;

  always #2 clk = ~clk;

  mw_seq_reader #(.ADDR_W(AW), .HI_CYC(HI), .LO_CYC(LO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(saddr),
    .count_i(cnt), .cs_o(cs), .sck_o(sck), .sdo_o(sdo), .sdi_i(sdi),
    .busy_o(busy), .done_o(done), .word_vld_o(vld), .word_o(word),
    .word_addr_o(waddr)
  );

  int checks = 0;
  int errors = 0;

  function automatic logic [15:0] mem_word(input logic [AW-1:0] a);
    return {a, ~a} ^ 16'h3C5A;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model state
  logic [AW-1:0] exp_q[$];
  logic [AW-1:0] frame_addr[$];
  logic prev_sck = 1'b0, prev_cs = 1'b0;
  int n = 0, post_rises = 0, frames = 0, hi_len = 0, lo_len = 0;
  logic rb[64];
  int cyc = 0;

  initial sdi = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (rst_n) begin
      if (sck && prev_sck) chk(sdo == rb[n], "R8 sdo stable high", sdo, rb[n]);
      // phase lengths
      if (sck) hi_len++;
      if (!sck && prev_sck) begin
        chk(hi_len == HI, "R7 high len", hi_len, HI);
        hi_len = 0;
      end
      if (!busy) lo_len = 0;
      else if (!sck) lo_len++;
      if (sck && !prev_sck) begin
        chk(lo_len == LO, "R7 low len", lo_len, LO);
        lo_len = 0;
        if (cs) begin
          n++;
          rb[n] = sdo;
          if (n == 4 + AW) sdi <= 1'b0;
          else if (n >= 5 + AW && n <= 20 + AW) begin
            logic [15:0] w;
            w = mem_word(frame_addr.size() ? frame_addr[0] : '0);
            sdi <= w[20 + AW - n];
          end else sdi <= 1'b1;
        end else post_rises++;
      end
      if (cs && !prev_cs) begin
        chk(!sck, "R1 cs rises sck low", sck, 0);
        if (frames > 0) chk(post_rises == 1, "R5 one cycle cs low", post_rises, 1);
        frames++;
        n = 0;
        post_rises = 0;
      end
      if (!cs && prev_cs) begin
        logic [AW-1:0] a;
        a = '0;
        chk(n == FRAME_RISES, "R4 rises per frame", n, FRAME_RISES);
        chk(rb[1] == 1'b0, "R1 lead cycle data 0", rb[1], 0);
        chk({rb[2], rb[3], rb[4]} == 3'b110, "R2 command bits",
            {rb[2], rb[3], rb[4]}, 3'b110);
        for (int i = 0; i < AW; i++) a = {a[AW-2:0], rb[5 + i]};
        chk(frame_addr.size() > 0 && a == frame_addr[0], "R3 address msb first",
            a, frame_addr.size() ? frame_addr[0] : 0);
        if (frame_addr.size()) void'(frame_addr.pop_front());
      end
      if (vld) begin
        chk(exp_q.size() > 0, "R6 unexpected word", 1, 0);
        if (exp_q.size()) begin
          logic [AW-1:0] ea;
          ea = exp_q.pop_front();
          chk(waddr == ea, "R6 word address", waddr, ea);
          chk(word == mem_word(ea), "R4 word data dummy dropped", word, mem_word(ea));
        end
      end
      if (done) begin
        chk(!busy, "R11 done with busy low", busy, 0);
        chk(exp_q.size() == 0, "R6 words delivered", exp_q.size(), 0);
        if (frames > 0) chk(post_rises == 1, "R5 final cs low cycle", post_rises, 1);
        frames = 0;
      end
    end
    prev_sck = sck;
    prev_cs = cs;
  end

  task automatic run(input logic [AW-1:0] a, input int c, input bit poke);
    @(negedge clk);
    start = 1'b1; saddr = a; cnt = (AW+1)'(c);
    for (int i = 0; i < c; i++) begin
      exp_q.push_back(a + AW'(i));
      frame_addr.push_back(a + AW'(i));
    end
    @(negedge clk);
    start = 1'b0;
    if (c == 0) begin
      chk(done && !busy, "R9 zero count done", {done, busy}, 2'b10);
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        chk(!cs && !sck && !sdo && !busy, "R9 lines quiet", {cs, sck, sdo, busy}, 0);
      end
    end else begin
      chk(busy && !done, "R10 busy after start", {busy, done}, 2'b10);
      for (int i = 0; !done; i++) begin
        if (poke && i == 100) begin
          start = 1'b1; saddr = a + 8'd77; cnt = 3;
        end else start = 1'b0;
        @(negedge clk);
        if (!done) chk(busy, "R10 busy held", busy, 1);
      end
      start = 1'b0;
      @(negedge clk);
      chk(!done && !busy, "R11 done single pulse", {done, busy}, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!cs && !sck && !sdo && !busy && !done && !vld, "R12 reset state",
        {cs, sck, sdo, busy, done, vld}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cs && !sck && !sdo, "R12 idle lines", {cs, sck, sdo}, 0);
    run(8'h05, 3, 1'b0);
    run(8'hFE, 4, 1'b0);   // R6 address wrap
    run(8'h40, 0, 1'b0);   // R9
    run(8'hA1, 2, 1'b1);   // R10 start ignored mid-run
    run(8'h80, 1, 1'b0);
    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule